// File: doc/BRIEF.md
# Load/Store Effective Address and Byte-Lane Steering Unit

This block sits between a core's register read stage and its data memory port. It forms the byte address of a load or store from a base register value and an offset. The offset is either a zero-extended immediate or a second register value, and it can be added or subtracted. The block also produces the value to be written back into the base register. In pre-indexed mode the access uses the adjusted address, and the base is updated only on request. In post-indexed mode the access uses the unmodified base, and the base is always updated afterwards.

The same unit also handles the data side of the access for byte, halfword and full-word sizes. It drives byte enables and replicates store data across the bus lanes. It extracts and zero-extends load data from the read bus. The byte order within a bus word is either little- or big-endian. That choice is captured from a configuration pin while reset is held and cannot change until the next reset. The address and data paths are purely combinational; the only register is the captured byte order. Alignment faults, sign extension and memory timing belong to other blocks.

Top module: `ls_addr_gen`

## Requirements
- R1: With `pre_index`=1 and `wb_req`=0, `mem_addr` equals base plus or minus offset, and `base_wb_en` is 0.
- R2: With `pre_index`=1 and `wb_req`=1, `mem_addr` and `base_wb_val` both equal base plus or minus offset, and `base_wb_en` is 1.
- R3: With `pre_index`=0 (post-indexing), `mem_addr` equals the unmodified base, `base_wb_val` equals base plus or minus offset, and `base_wb_en` is 1 whatever `wb_req` is.
- R4: The offset is `reg_off` when `off_is_reg`=1 and otherwise `imm_off` zero-extended; the other source has no effect. `off_sub`=1 subtracts, and sums wrap modulo 2^32.
- R5: `acc_size` encoding is 00 byte, 01 halfword, 10 and 11 full word. A byte access asserts exactly one bit of `mem_be`, a halfword exactly two adjacent bits (bits 1:0 or 3:2), and a word all four.
- R6: In little-endian mode, byte address offset n (`mem_addr[1:0]`) selects bus lane n (bits 8n+7:8n). In big-endian mode it selects lane 3-n, so offset 0 maps to bits 31:24. A halfword at offset 0 uses lanes 1:0 in little-endian mode and lanes 3:2 in big-endian mode.
- R7: For a store, `mem_wdata` holds `st_data[7:0]` copied into every lane for a byte, `st_data[15:0]` copied into both halves for a halfword, and `st_data` unchanged for a word.
- R8: `ld_data` is the addressed byte or halfword of `rd_bus`, zero-extended to 32 bits, or the whole of `rd_bus` for a word.
- R9: The byte order is the value of `big_endian_cfg` (1 = big-endian) sampled on clock edges while `rst_n` is low; changes of `big_endian_cfg` after reset is released have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the byte-order capture |
| rst_n | input | 1 | Active-low synchronous reset; byte order is captured while low |
| big_endian_cfg | input | 1 | Byte-order selection, 1 = big-endian |
| base_val | input | 32 | Base register value |
| imm_off | input | 12 | Immediate offset, zero-extended |
| reg_off | input | 32 | Register offset value |
| off_is_reg | input | 1 | 1 selects `reg_off` as the offset |
| off_sub | input | 1 | 1 subtracts the offset from the base |
| pre_index | input | 1 | 1 = pre-indexed, 0 = post-indexed |
| wb_req | input | 1 | Writeback request for pre-indexed mode |
| acc_size | input | 2 | Access size: 00 byte, 01 halfword, 1x word |
| st_data | input | 32 | Store data, right-justified |
| rd_bus | input | 32 | Read data from the memory bus |
| mem_addr | output | 32 | Effective byte address |
| mem_be | output | 4 | Byte-lane enables |
| mem_wdata | output | 32 | Lane-steered store data |
| ld_data | output | 32 | Zero-extended load result |
| base_wb_val | output | 32 | Value for the base register |
| base_wb_en | output | 1 | Base register write enable |

## Verification
Every output except the byte order is a combinational function of the current inputs. A wrong adder, mode decode or lane decode therefore shows on `mem_addr`, `base_wb_val` or `mem_be` in the same cycle as the stimulus. The bench samples the outputs one nanosecond after it drives the inputs. A wrongly captured or drifting byte-order register has no direct output of its own. It shows only as a mirrored lane choice on the next byte or halfword access. The bench therefore issues such accesses right after reset and again after toggling the configuration pin.

// File: rtl/lsag_pkg.sv
package lsag_pkg;
   typedef enum logic [1:0] {
      SZ_BYTE = 2'b00,
      SZ_HALF = 2'b01,
      SZ_WORD = 2'b10,
      SZ_WIDE = 2'b11
   } acc_size_e;
endpackage

// File: rtl/lsag_endian_latch.sv
module lsag_endian_latch (
   input  logic clk,
   input  logic rst_n,
   input  logic cfg_i,
   output logic big_o
);
   logic big_q;

   always_ff @(posedge clk) begin
      if (!rst_n) big_q <= cfg_i;
   end

   assign big_o = big_q;

   // R9
   endian_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      rst_n |=> $stable(big_q));
endmodule

// File: rtl/lsag_index_unit.sv
module lsag_index_unit #(
   parameter int ADDR_W     = 32,
   parameter int IMM_W      = 12,
   parameter bit ONE_ADDER  = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] base_i,
   input  logic [IMM_W-1:0]  imm_i,
   input  logic [ADDR_W-1:0] roff_i,
   input  logic              use_reg_i,
   input  logic              sub_i,
   input  logic              pre_i,
   input  logic              wb_i,
   output logic [ADDR_W-1:0] addr_o,
   output logic [ADDR_W-1:0] wb_val_o,
   output logic              wb_en_o
);
   logic [ADDR_W-1:0] off_ext;
   logic [ADDR_W-1:0] off_sel;
   logic [ADDR_W-1:0] sum;

   generate
      if (IMM_W < 1 || IMM_W > ADDR_W) begin : g_bad_imm
         $error("lsag_index_unit: IMM_W must lie in 1..ADDR_W");
      end
      if (IMM_W < ADDR_W) begin : g_zext
         assign off_ext = {{(ADDR_W-IMM_W){1'b0}}, imm_i};
      end else begin : g_full
         assign off_ext = imm_i;
      end
   endgenerate

   assign off_sel = use_reg_i ? roff_i : off_ext;

   generate
      if (ONE_ADDER) begin : g_shared
         logic [ADDR_W-1:0] opnd;
         assign opnd = sub_i ? ~off_sel : off_sel;
         assign sum  = base_i + opnd + {{(ADDR_W-1){1'b0}}, sub_i};
      end else begin : g_dual
         logic [ADDR_W-1:0] s_add;
         logic [ADDR_W-1:0] s_sub;
         assign s_add = base_i + off_sel;
         assign s_sub = base_i - off_sel;
         assign sum   = sub_i ? s_sub : s_add;
      end
   endgenerate

   assign addr_o   = pre_i ? sum : base_i;
   assign wb_val_o = sum;
   assign wb_en_o  = !pre_i || wb_i;

   // R1
   pre_nowb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_i && !wb_i) |-> (!wb_en_o && addr_o == wb_val_o));
   // R2
   pre_wb_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pre_i && wb_i) |-> (wb_en_o && addr_o == wb_val_o));
   // R3
   post_idx_chk: assert property (@(posedge clk) disable iff (!rst_n)
      !pre_i |-> (wb_en_o && addr_o == base_i));
   // R4
   sub_inverse_chk: assert property (@(posedge clk) disable iff (!rst_n)
      sub_i |-> (wb_val_o + off_sel == base_i));
endmodule

// File: rtl/lsag_lane_steer.sv
module lsag_lane_steer
   import lsag_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_i,
   input  acc_size_e         size_i,
   input  logic [$clog2(DATA_W/8)-1:0] addr_lo_i,
   input  logic [DATA_W-1:0] st_data_i,
   input  logic [DATA_W-1:0] rd_bus_i,
   output logic [DATA_W/8-1:0] be_o,
   output logic [DATA_W-1:0] wdata_o,
   output logic [DATA_W-1:0] ld_o
);
   localparam int LANES = DATA_W / 8;
   localparam int HP    = LANES / 2;
   localparam int LW    = $clog2(LANES);

   logic [LANES-1:0] byte_hit;
   logic [LANES-1:0] half_hit;
   logic [7:0]       lane_byte [LANES];

   generate
      for (genvar k = 0; k < LANES; k++) begin : g_lane
         localparam logic [LW-1:0] LE_IDX = LW'(k);
         localparam logic [LW-1:0] BE_IDX = LW'(LANES-1-k);
         logic [LW-1:0] idx;
         assign idx         = big_i ? BE_IDX : LE_IDX;
         assign byte_hit[k] = (idx == addr_lo_i);
         assign half_hit[k] = (idx[LW-1:1] == addr_lo_i[LW-1:1]);
         assign be_o[k]     = (size_i == SZ_BYTE) ? byte_hit[k] :
                              (size_i == SZ_HALF) ? half_hit[k] : 1'b1;
         assign lane_byte[k] = rd_bus_i[8*k +: 8];
      end
   endgenerate

   logic [7:0]  byte_v;
   logic [15:0] half_v;

   always_comb begin
      byte_v = '0;
      for (int k = 0; k < LANES; k++) begin
         if (byte_hit[k]) byte_v = lane_byte[k];
      end
      half_v = '0;
      for (int p = 0; p < HP; p++) begin
         if (half_hit[2*p]) half_v = rd_bus_i[16*p +: 16];
      end
   end

   always_comb begin
      case (size_i)
         SZ_BYTE: begin
            ld_o    = {{(DATA_W-8){1'b0}}, byte_v};
            wdata_o = {LANES{st_data_i[7:0]}};
         end
         SZ_HALF: begin
            ld_o    = {{(DATA_W-16){1'b0}}, half_v};
            wdata_o = {HP{st_data_i[15:0]}};
         end
         default: begin
            ld_o    = rd_bus_i;
            wdata_o = st_data_i;
         end
      endcase
   end

   // R5
   byte_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == SZ_BYTE) |-> ($countones(be_o) == 1));
   // R5
   half_be_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == SZ_HALF) |-> ($countones(be_o) == 2));
   // R6
   le_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (!big_i && size_i == SZ_BYTE && addr_lo_i == '0) |-> be_o[0]);
   // R6
   be_lane0_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (big_i && size_i == SZ_BYTE && addr_lo_i == '0) |-> be_o[LANES-1]);
   // R7
   byte_rep_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == SZ_BYTE) |-> (wdata_o[7:0] == wdata_o[DATA_W-1 -: 8]));
   // R8
   byte_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == SZ_BYTE) |-> (ld_o[DATA_W-1:8] == '0));
   // R8
   half_zext_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (size_i == SZ_HALF) |-> (ld_o[DATA_W-1:16] == '0));
endmodule

// File: rtl/ls_addr_gen.sv
module ls_addr_gen
   import lsag_pkg::*;
#(
   parameter int ADDR_W    = 32,
   parameter int DATA_W    = 32,
   parameter int IMM_W     = 12,
   parameter bit ONE_ADDER = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              big_endian_cfg,
   input  logic [ADDR_W-1:0] base_val,
   input  logic [IMM_W-1:0]  imm_off,
   input  logic [ADDR_W-1:0] reg_off,
   input  logic              off_is_reg,
   input  logic              off_sub,
   input  logic              pre_index,
   input  logic              wb_req,
   input  logic [1:0]        acc_size,
   input  logic [DATA_W-1:0] st_data,
   input  logic [DATA_W-1:0] rd_bus,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W/8-1:0] mem_be,
   output logic [DATA_W-1:0] mem_wdata,
   output logic [DATA_W-1:0] ld_data,
   output logic [ADDR_W-1:0] base_wb_val,
   output logic              base_wb_en
);
   localparam int LANES = DATA_W / 8;
   localparam int LW    = $clog2(LANES);

   generate
      if (DATA_W < 32 || (DATA_W & (DATA_W - 1)) != 0) begin : g_bad_data
         $error("ls_addr_gen: DATA_W must be a power of two of at least 32");
      end
      if (ADDR_W < LW + 1) begin : g_bad_addr
         $error("ls_addr_gen: ADDR_W too narrow for the lane index");
      end
   endgenerate

   logic big_mode;

   lsag_endian_latch u_endian (
      .clk   (clk),
      .rst_n (rst_n),
      .cfg_i (big_endian_cfg),
      .big_o (big_mode)
   );

   lsag_index_unit #(
      .ADDR_W    (ADDR_W),
      .IMM_W     (IMM_W),
      .ONE_ADDER (ONE_ADDER)
   ) u_index (
      .clk       (clk),
      .rst_n     (rst_n),
      .base_i    (base_val),
      .imm_i     (imm_off),
      .roff_i    (reg_off),
      .use_reg_i (off_is_reg),
      .sub_i     (off_sub),
      .pre_i     (pre_index),
      .wb_i      (wb_req),
      .addr_o    (mem_addr),
      .wb_val_o  (base_wb_val),
      .wb_en_o   (base_wb_en)
   );

   lsag_lane_steer #(
      .DATA_W (DATA_W)
   ) u_steer (
      .clk       (clk),
      .rst_n     (rst_n),
      .big_i     (big_mode),
      .size_i    (acc_size_e'(acc_size)),
      .addr_lo_i (mem_addr[LW-1:0]),
      .st_data_i (st_data),
      .rd_bus_i  (rd_bus),
      .be_o      (mem_be),
      .wdata_o   (mem_wdata),
      .ld_o      (ld_data)
   );
endmodule

// File: tb/tb_ls_addr_gen.sv
module tb_ls_addr_gen;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        big_endian_cfg;
   logic [31:0] base_val;
   logic [11:0] imm_off;
   logic [31:0] reg_off;
   logic        off_is_reg, off_sub, pre_index, wb_req;
   logic [1:0]  acc_size;
   logic [31:0] st_data, rd_bus;
   logic [31:0] mem_addr, mem_wdata, ld_data, base_wb_val;
   logic [3:0]  mem_be;
   logic        base_wb_en;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;

   always #2 clk = ~clk;

   ls_addr_gen dut (
      .clk(clk), .rst_n(rst_n), .big_endian_cfg(big_endian_cfg),
      .base_val(base_val), .imm_off(imm_off), .reg_off(reg_off),
      .off_is_reg(off_is_reg), .off_sub(off_sub), .pre_index(pre_index),
      .wb_req(wb_req), .acc_size(acc_size), .st_data(st_data), .rd_bus(rd_bus),
      .mem_addr(mem_addr), .mem_be(mem_be), .mem_wdata(mem_wdata),
      .ld_data(ld_data), .base_wb_val(base_wb_val), .base_wb_en(base_wb_en)
   );

   typedef struct packed {
      logic [31:0] base;
      logic [11:0] imm;
      logic [31:0] roff;
      logic        use_reg;
      logic        sub;
      logic        pre;
      logic        wb;
      logic [1:0]  size;
      logic [31:0] e_addr;
      logic [31:0] e_wbv;
      logic        e_wben;
      logic [3:0]  e_be;
   } vec_t;

   localparam int NV = 11;
   localparam vec_t TBL [NV] = '{
      '{32'h1000, 12'h010, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'b10, 32'h1010, 32'h1010, 1'b0, 4'hF},
      '{32'h1000, 12'h010, 32'h0,   1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 32'h1010, 32'h1010, 1'b1, 4'hF},
      '{32'h2000, 12'h004, 32'h0,   1'b0, 1'b0, 1'b0, 1'b0, 2'b10, 32'h2000, 32'h2004, 1'b1, 4'hF},
      '{32'h2000, 12'h000, 32'h100, 1'b1, 1'b1, 1'b1, 1'b1, 2'b00, 32'h1F00, 32'h1F00, 1'b1, 4'h1},
      '{32'h3003, 12'h000, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h3003, 32'h3003, 1'b0, 4'h8},
      '{32'h3002, 12'h000, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'b01, 32'h3002, 32'h3002, 1'b0, 4'hC},
      '{32'h0010, 12'h000, 32'h20,  1'b1, 1'b1, 1'b0, 1'b0, 2'b00, 32'h0010, 32'hFFFFFFF0, 1'b1, 4'h1},
      '{32'hFFFFFFFC, 12'h008, 32'h0, 1'b0, 1'b0, 1'b1, 1'b1, 2'b10, 32'h4, 32'h4, 1'b1, 4'hF},
      '{32'h5001, 12'hFFF, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'b00, 32'h6000, 32'h6000, 1'b0, 4'h1},
      '{32'h0100, 12'h7FF, 32'h8,   1'b1, 1'b0, 1'b1, 1'b0, 2'b10, 32'h0108, 32'h0108, 1'b0, 4'hF},
      '{32'h0400, 12'h000, 32'h0,   1'b0, 1'b0, 1'b1, 1'b0, 2'b11, 32'h0400, 32'h0400, 1'b0, 4'hF}
   };

   task automatic chk(input string req, input string what,
                      input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %08h expected %08h", req, what, act, exp);
      end
   endtask

   task automatic do_reset(input logic cfg);
      rst_n          = 1'b0;
      big_endian_cfg = cfg;
      repeat (3) @(posedge clk);
      @(negedge clk);
      rst_n = 1'b1;
   endtask

   task automatic drive(input logic [31:0] b, input logic [1:0] sz);
      @(negedge clk);
      base_val = b; imm_off = '0; reg_off = '0; off_is_reg = 1'b0;
      off_sub = 1'b0; pre_index = 1'b1; wb_req = 1'b0; acc_size = sz;
      #1;
   endtask

   task automatic finish_run();
      if (!done) begin
         done = 1'b1;
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   endtask

   initial begin
      #(200000 * 4);
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      finish_run();
   end

   initial begin
      base_val = '0; imm_off = '0; reg_off = '0; off_is_reg = 1'b0;
      off_sub = 1'b0; pre_index = 1'b1; wb_req = 1'b0; acc_size = 2'b00;
      st_data = 32'hAABBCCDD; rd_bus = 32'h11223344;
      do_reset(1'b0);

      // reset state: little-endian captured, byte at offset 0 uses lane 0 (R9, R6)
      drive(32'h0, 2'b00);
      chk("R9", "reset LE be", {28'h0, mem_be}, 32'h1);

      // table of address-mode vectors, little-endian
      for (int i = 0; i < NV; i++) begin
         @(negedge clk);
         base_val   = TBL[i].base;
         imm_off    = TBL[i].imm;
         reg_off    = TBL[i].roff;
         off_is_reg = TBL[i].use_reg;
         off_sub    = TBL[i].sub;
         pre_index  = TBL[i].pre;
         wb_req     = TBL[i].wb;
         acc_size   = TBL[i].size;
         #1;
         if (!TBL[i].pre) begin
            chk("R3", "addr", mem_addr, TBL[i].e_addr);
            chk("R3", "wb_en", {31'h0, base_wb_en}, {31'h0, TBL[i].e_wben});
         end else if (TBL[i].wb) begin
            chk("R2", "addr", mem_addr, TBL[i].e_addr);
            chk("R2", "wb_en", {31'h0, base_wb_en}, {31'h0, TBL[i].e_wben});
         end else begin
            chk("R1", "addr", mem_addr, TBL[i].e_addr);
            chk("R1", "wb_en", {31'h0, base_wb_en}, {31'h0, TBL[i].e_wben});
         end
         chk("R4", "wb_val", base_wb_val, TBL[i].e_wbv);
         chk("R5", "be", {28'h0, mem_be}, {28'h0, TBL[i].e_be});
      end

      // little-endian data steering
      drive(32'h0, 2'b00);
      chk("R7", "LE byte wdata", mem_wdata, 32'hDDDDDDDD);
      chk("R8", "LE byte ld @0", ld_data, 32'h44);
      drive(32'h1, 2'b00);
      chk("R6", "LE byte be @1", {28'h0, mem_be}, 32'h2);
      chk("R8", "LE byte ld @1", ld_data, 32'h33);
      drive(32'h3, 2'b00);
      chk("R8", "LE byte ld @3", ld_data, 32'h11);
      drive(32'h0, 2'b01);
      chk("R6", "LE half be @0", {28'h0, mem_be}, 32'h3);
      chk("R8", "LE half ld @0", ld_data, 32'h3344);
      chk("R7", "LE half wdata", mem_wdata, 32'hCCDDCCDD);
      drive(32'h2, 2'b01);
      chk("R8", "LE half ld @2", ld_data, 32'h1122);
      drive(32'h0, 2'b10);
      chk("R8", "word ld", ld_data, 32'h11223344);
      chk("R7", "word wdata", mem_wdata, 32'hAABBCCDD);

      // big-endian after a second reset
      do_reset(1'b1);
      drive(32'h0, 2'b00);
      chk("R6", "BE byte be @0", {28'h0, mem_be}, 32'h8);
      chk("R8", "BE byte ld @0", ld_data, 32'h11);
      drive(32'h3, 2'b00);
      chk("R6", "BE byte be @3", {28'h0, mem_be}, 32'h1);
      chk("R8", "BE byte ld @3", ld_data, 32'h44);
      drive(32'h0, 2'b01);
      chk("R6", "BE half be @0", {28'h0, mem_be}, 32'hC);
      chk("R8", "BE half ld @0", ld_data, 32'h1122);
      chk("R7", "BE half wdata", mem_wdata, 32'hCCDDCCDD);
      drive(32'h2, 2'b01);
      chk("R6", "BE half be @2", {28'h0, mem_be}, 32'h3);
      chk("R8", "BE half ld @2", ld_data, 32'h3344);

      // configuration pin moves after reset: no effect (R9)
      @(negedge clk);
      big_endian_cfg = 1'b0;
      repeat (4) @(posedge clk);
      drive(32'h0, 2'b00);
      chk("R9", "BE held be @0", {28'h0, mem_be}, 32'h8);
      chk("R9", "BE held ld @0", ld_data, 32'h11);

      finish_run();
   end
endmodule